// File: doc/BRIEF.md
# Random generator control and status interface

This block is the software-facing register front end of a hardware random number generator. A host on a simple 32-bit register bus starts seed generation or a self test through one-shot command bits, watches completion and error flags in a status register, and pulls 32-bit random words from a 16-entry buffer whose fill level it can read. A single interrupt line reports a finished operation and latched errors, each of which can be masked on its own. Two separate clear commands let software drop a done indication without losing error information, or wipe both at once after reading the error register.

The physical entropy source is replaced by a parameterised Galois LFSR. It is mixed with a free-running counter at every successful seed. An input pin forces a statistical failure at the end of a seed operation, so that the retry path of the driver can be exercised. With automatic reseeding enabled, the block starts a fresh seed once a programmable number of words has been served since the last seed began.

Top module: `rng_ctrl_top`

## Requirements
- R1: A read of byte offset 0x00 returns the type code parameter in bits 31:28, the major revision in bits 15:8 and the minor revision in bits 7:0, with all other bits zero.
- R2: The control register at offset 0x08 holds auto-reseed in bit 4, done-interrupt mask in bit 5 and error-interrupt mask in bit 6, resets to 0x60, and reads zero in all other bits.
- R3: A write to the command register at offset 0x04 starts a self test with bit 0 or a seed with bit 1 (self test wins if both are set). The register reads as zero, and a start that arrives while an operation is running is ignored.
- R4: A seed sets status bit 5 exactly SEED_CYCLES clock edges after the command edge. A self test sets status bit 4 exactly TEST_CYCLES edges after the command edge.
- R5: If force_stat_fail is high in the final cycle of a seed, error register bit 3 is set and the seed does not count as valid. A new seed command is accepted while that error is held.
- R6: No word enters the buffer before a valid seed exists. After that, one word is added per cycle while the buffer is not full and no operation is running. Status bits 11:8 show the fill level, saturated at 15, and reset empties the buffer.
- R7: A read of offset 0x14 returns the oldest buffered word and removes it. The words are nonzero, and consecutive words differ.
- R8: A read of offset 0x14 with an empty buffer returns zero and sets error register bit 0.
- R9: Status bit 16 is high exactly when any error register bit is set.
- R10: Command bit 4 clears both done bits only while the error register is zero. Otherwise it has no effect.
- R11: Command bit 5 clears the error register and both done bits.
- R12: irq is high when a done bit is set and bit 5 of the control register is clear, or when an error bit is set and bit 6 of the control register is clear.
- R13: With control bit 4 set, a seed starts on its own once RESEED_WORDS words have been read since the last seed started. With bit 4 clear, no automatic seed happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| force_stat_fail | input | 1 | Test hook: forces a statistical failure at seed completion |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with SEED_CYCLES of 8, TEST_CYCLES of 5 and RESEED_WORDS of 4. This brings the 2^20-word automatic reseed threshold down to a few bus reads, so both the trigger and its absence can be observed through the seed-done bit. The short operation lengths let the bench probe the exact edge on which each done bit appears. They also let it issue a second command while the first is still running, and fill the 16-entry buffer to its saturated level reading within a few dozen cycles.

// File: rtl/rng_pkg.sv
package rng_pkg;
  // register byte offsets (software decodes these)
  localparam logic [7:0] A_IDENT = 8'h00;
  localparam logic [7:0] A_CMD   = 8'h04;
  localparam logic [7:0] A_CTRL  = 8'h08;
  localparam logic [7:0] A_STAT  = 8'h0C;
  localparam logic [7:0] A_ERR   = 8'h10;
  localparam logic [7:0] A_DATA  = 8'h14;

  // command bits
  localparam int C_TEST   = 0;
  localparam int C_SEED   = 1;
  localparam int C_CLRIRQ = 4;
  localparam int C_CLRERR = 5;

  // control bits
  localparam int K_AUTO  = 4;
  localparam int K_MDONE = 5;
  localparam int K_MERR  = 6;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_SEED = 2'd1,
    OP_TEST = 2'd2
  } op_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] POLY = 32'h8020_0003,
  parameter logic [W-1:0] INIT = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         reseed,
  input  logic [W-1:0] mix,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (reseed) begin
      st_d = (st_q ^ mix) | {{(W-1){1'b0}}, 1'b1};
    end else if (adv) begin
      st_d = (st_q >> 1) ^ (st_q[0] ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= INIT;
    else if (reseed || adv) st_q <= st_d;
  end

  assign state = st_q;

  // R7: stand-in source never reaches the all-zero lock-up state
  p_state_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = do_push ? wrap_inc(wp_q) : wp_q;
    rp_d  = do_pop  ? wrap_inc(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign count   = cnt_q;

  // R6: fill level never exceeds the buffer depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8: a pop from an empty buffer leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/rng_seq.sv
module rng_seq
  import rng_pkg::*;
#(
  parameter int unsigned SEED_CYCLES = 64,
  parameter int unsigned TEST_CYCLES = 32,
  localparam int unsigned MAXC = (SEED_CYCLES > TEST_CYCLES) ? SEED_CYCLES : TEST_CYCLES,
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_test,
  input  logic req_seed,
  output logic busy,
  output logic seed_go,
  output logic fin_seed,
  output logic fin_test
);
  op_e           op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last    = (op_q != OP_IDLE) && (cnt_q == '0);
  assign busy    = (op_q != OP_IDLE);
  assign seed_go = (op_q == OP_IDLE) && req_seed && !req_test;

  always_comb begin
    op_d  = op_q;
    cnt_d = cnt_q;
    if (op_q == OP_IDLE) begin
      if (req_test) begin
        op_d  = OP_TEST;
        cnt_d = CW'(TEST_CYCLES - 1);
      end else if (req_seed) begin
        op_d  = OP_SEED;
        cnt_d = CW'(SEED_CYCLES - 1);
      end
    end else if (last) begin
      op_d = OP_IDLE;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
    end
  end

  assign fin_seed = last && (op_q == OP_SEED);
  assign fin_test = last && (op_q == OP_TEST);

  // R3, R4: a running operation counts down undisturbed by new starts
  p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (op_q == $past(op_q)) && (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rng_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter logic [3:0]  TYPE_CODE    = 4'd2,
  parameter logic [7:0]  REV_MAJ      = 8'd1,
  parameter logic [7:0]  REV_MIN      = 8'd3,
  parameter int unsigned FIFO_DEPTH   = 16,
  parameter int unsigned SEED_CYCLES  = 64,
  parameter int unsigned TEST_CYCLES  = 32,
  parameter int unsigned RESEED_WORDS = 1 << 20,
  parameter logic [31:0] LFSR_POLY    = 32'h8020_0003,
  parameter logic [31:0] LFSR_INIT    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              force_stat_fail,
  output logic              irq
);
  localparam int unsigned FCW = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned SW  = $clog2(RESEED_WORDS + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // bus decode
  logic wr, rd, cmd_wr, ctrl_wr, data_rd;
  logic req_test, req_seed, clr_irq, clr_err;
  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign cmd_wr  = wr && (bus_addr == ADDR_W'(A_CMD));
  assign ctrl_wr = wr && (bus_addr == ADDR_W'(A_CTRL));
  assign data_rd = rd && (bus_addr == ADDR_W'(A_DATA));
  assign clr_irq = cmd_wr && bus_wdata[C_CLRIRQ];
  assign clr_err = cmd_wr && bus_wdata[C_CLRERR];

  // state
  logic          auto_q, mdone_q, merr_q;
  logic          auto_d, mdone_d, merr_d;
  logic          sdone_q, tdone_q, sdone_d, tdone_d;
  logic          uflow_q, stat_q, uflow_d, stat_d;
  logic          seeded_q, seeded_d;
  logic [SW-1:0] served_q, served_d;
  logic [31:0]   stir_q;
  logic          err_any, done_any, auto_due;

  // submodule wires
  logic           busy, seed_go, fin_seed, fin_test;
  logic           f_push, f_pop, f_full, f_empty;
  logic [FCW-1:0] f_count;
  logic [31:0]    f_out, rnd;
  logic           seed_ok;

  assign err_any  = uflow_q || stat_q;
  assign done_any = sdone_q || tdone_q;
  assign auto_due = auto_q && (served_q == SW'(RESEED_WORDS));
  assign req_test = cmd_wr && bus_wdata[C_TEST];
  assign req_seed = (cmd_wr && bus_wdata[C_SEED]) || auto_due;
  assign seed_ok  = fin_seed && !force_stat_fail;
  assign f_pop    = data_rd && !f_empty;
  assign f_push   = seeded_q && !busy && !f_full;

  rng_seq #(
    .SEED_CYCLES (SEED_CYCLES),
    .TEST_CYCLES (TEST_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .req_test (req_test),
    .req_seed (req_seed),
    .busy     (busy),
    .seed_go  (seed_go),
    .fin_seed (fin_seed),
    .fin_test (fin_test)
  );

  rng_lfsr #(
    .W    (32),
    .POLY (LFSR_POLY),
    .INIT (LFSR_INIT)
  ) u_src (
    .clk    (clk),
    .rst_n  (rst_ni),
    .adv    (f_push),
    .reseed (seed_ok),
    .mix    (stir_q),
    .state  (rnd)
  );

  rng_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (32)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_ni),
    .push    (f_push),
    .pop     (f_pop),
    .wr_data (rnd),
    .rd_data (f_out),
    .count   (f_count),
    .full    (f_full),
    .empty   (f_empty)
  );

  // next state
  always_comb begin
    auto_d  = auto_q;
    mdone_d = mdone_q;
    merr_d  = merr_q;
    if (ctrl_wr) begin
      auto_d  = bus_wdata[K_AUTO];
      mdone_d = bus_wdata[K_MDONE];
      merr_d  = bus_wdata[K_MERR];
    end

    sdone_d = sdone_q;
    tdone_d = tdone_q;
    if (clr_err || (clr_irq && !err_any)) begin
      sdone_d = 1'b0;
      tdone_d = 1'b0;
    end
    if (fin_seed) sdone_d = 1'b1;
    if (fin_test) tdone_d = 1'b1;

    uflow_d = clr_err ? 1'b0 : uflow_q;
    stat_d  = clr_err ? 1'b0 : stat_q;
    if (data_rd && f_empty)          uflow_d = 1'b1;
    if (fin_seed && force_stat_fail) stat_d  = 1'b1;

    seeded_d = seeded_q || seed_ok;

    served_d = served_q;
    if (seed_go) served_d = '0;
    else if (f_pop && (served_q != SW'(RESEED_WORDS))) served_d = served_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q   <= 1'b0;
      mdone_q  <= 1'b1;
      merr_q   <= 1'b1;
      sdone_q  <= 1'b0;
      tdone_q  <= 1'b0;
      uflow_q  <= 1'b0;
      stat_q   <= 1'b0;
      seeded_q <= 1'b0;
      served_q <= '0;
      stir_q   <= '0;
    end else begin
      auto_q   <= auto_d;
      mdone_q  <= mdone_d;
      merr_q   <= merr_d;
      sdone_q  <= sdone_d;
      tdone_q  <= tdone_d;
      uflow_q  <= uflow_d;
      stat_q   <= stat_d;
      seeded_q <= seeded_d;
      served_q <= served_d;
      stir_q   <= stir_q + 32'h9E37_79B9;
    end
  end

  // read mux
  logic [3:0]  lvl;
  logic [31:0] rmux;
  assign lvl = (int'(f_count) > 15) ? 4'hF : 4'(f_count);

  always_comb begin
    rmux = '0;
    case (bus_addr)
      ADDR_W'(A_IDENT): rmux = {TYPE_CODE, 12'h000, REV_MAJ, REV_MIN};
      ADDR_W'(A_CTRL):  rmux = {25'b0, merr_q, mdone_q, auto_q, 4'b0};
      ADDR_W'(A_STAT):  rmux = {15'b0, err_any, 4'b0, lvl, 2'b0, sdone_q, tdone_q, 4'b0};
      ADDR_W'(A_ERR):   rmux = {28'b0, stat_q, 2'b0, uflow_q};
      ADDR_W'(A_DATA):  rmux = f_empty ? 32'h0 : f_out;
      default:          rmux = '0;
    endcase
  end

  assign bus_rdata = rd ? rmux : 32'h0;
  assign irq       = (done_any && !mdone_q) || (err_any && !merr_q);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  // R8: reading an empty buffer latches the underflow flag
  p_uflow_latch_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_rd && f_empty) |=> uflow_q);

  // R10: clear-interrupt leaves done bits alone while an error is held
  p_clrirq_blocked_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_irq && !clr_err && err_any && sdone_q) |=> sdone_q);

  // R6: nothing reaches the buffer before a valid seed
  p_no_fill_unseeded_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !seeded_q |-> (f_count == '0));

  // R13: a due automatic reseed starts the sequencer
  p_autoseed_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    (auto_due && !busy && !req_test) |=> busy);
endmodule

// File: tb/tb_rng_ctrl_top.sv
module tb_rng_ctrl_top;
  localparam int CLK_P = 10;
  localparam int SEEDC = 8;
  localparam int TESTC = 5;
  localparam int RWORDS = 4;

  localparam logic [7:0] ID = 8'h00, CMD = 8'h04, CTL = 8'h08,
                         STA = 8'h0C, ERR = 8'h10, DAT = 8'h14;

  logic        clk, rst_n, bus_req, bus_we, force_stat_fail, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int ntests = 0;
  int nfails = 0;
  bit finished = 0;

  rng_ctrl_top #(
    .SEED_CYCLES  (SEEDC),
    .TEST_CYCLES  (TESTC),
    .RESEED_WORDS (RWORDS)
  ) dut (
    .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .force_stat_fail (force_stat_fail), .irq (irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] m;
    logic [31:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, ID,  32'h0, 32'hFFFF_FFFF, 32'h2000_0103, 4'd1},  // R1
    '{1'b0, CTL, 32'h0, 32'hFFFF_FFFF, 32'h0000_0060, 4'd2},  // R2
    '{1'b1, CTL, 32'hFFFF_FFFF, 32'h0, 32'h0, 4'd2},
    '{1'b0, CTL, 32'h0, 32'hFFFF_FFFF, 32'h0000_0070, 4'd2},  // R2
    '{1'b1, CTL, 32'h0000_0060, 32'h0, 32'h0, 4'd2},
    '{1'b0, CMD, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},  // R3
    '{1'b0, STA, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9},  // R9
    '{1'b0, ERR, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},  // R8
    '{1'b0, DAT, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},  // R8
    '{1'b0, ERR, 32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 4'd8},  // R8
    '{1'b0, STA, 32'h0, 32'h0001_0000, 32'h0001_0000, 4'd9},  // R9
    '{1'b1, CMD, 32'h0000_0010, 32'h0, 32'h0, 4'd10},
    '{1'b0, ERR, 32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 4'd10}, // R10
    '{1'b1, CMD, 32'h0000_0020, 32'h0, 32'h0, 4'd11},
    '{1'b0, ERR, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11}, // R11
    '{1'b0, STA, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 1'b0;
    #1;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
  endtask

  initial begin
    logic [31:0] v, w1, w2;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    force_stat_fail = 1'b0;
    rst_n = 1'b0;
    waitn(1);
    do_reset();

    check("R12 irq after reset", {31'b0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr32(VEC[i].a, VEC[i].d);
      end else begin
        rd32(VEC[i].a, v);
        check($sformatf("R%0d vector %0d", VEC[i].rq, i), v & VEC[i].m, VEC[i].e);
      end
    end

    // R4 self-test timing
    wr32(CMD, 32'h1);
    waitn(TESTC - 1);
    peek(STA, v); check("R4 test not yet done", v & 32'h30, 32'h00);
    waitn(1);
    peek(STA, v); check("R4 test done on time", v & 32'h30, 32'h10);
    check("R12 done masked", {31'b0, irq}, 32'h0);
    wr32(CTL, 32'h40);
    check("R12 done unmasked", {31'b0, irq}, 32'h1);
    wr32(CMD, 32'h10);
    peek(STA, v); check("R10 clear without error", v & 32'h30, 32'h00);
    check("R12 irq after clear", {31'b0, irq}, 32'h0);

    // R3 start during busy ignored
    wr32(CMD, 32'h1);
    wr32(CMD, 32'h2);
    waitn(SEEDC + TESTC);
    peek(STA, v); check("R3 seed while busy ignored", v & 32'h30, 32'h10);
    wr32(CMD, 32'h10);

    // R5 forced statistical failure
    force_stat_fail = 1'b1;
    wr32(CMD, 32'h2);
    waitn(SEEDC - 1);
    peek(STA, v); check("R4 seed not yet done", v & 32'h20, 32'h00);
    waitn(1);
    force_stat_fail = 1'b0;
    peek(ERR, v); check("R5 stat error bit", v, 32'h8);
    peek(STA, v); check("R9 status with stat error", v & 32'h1_0F30, 32'h1_0020);
    waitn(5);
    peek(STA, v); check("R6 no fill after failed seed", v & 32'hF00, 32'h0);
    wr32(CTL, 32'h20);
    check("R12 error unmasked", {31'b0, irq}, 32'h1);
    wr32(CTL, 32'h60);
    check("R12 all masked", {31'b0, irq}, 32'h0);
    wr32(CMD, 32'h10);
    peek(STA, v); check("R10 clear blocked by error", v & 32'h20, 32'h20);

    // R5 reseed accepted while error held, R6 fill rate
    wr32(CMD, 32'h2);
    waitn(SEEDC + 3);
    peek(STA, v); check("R6 fill one per cycle", v & 32'hF00, 32'h300);
    peek(ERR, v); check("R5 error still held", v, 32'h8);
    waitn(20);
    peek(STA, v); check("R6 level saturates", v & 32'hF00, 32'hF00);

    // R11 clear error
    wr32(CMD, 32'h20);
    peek(ERR, v); check("R11 error cleared", v, 32'h0);
    peek(STA, v); check("R11 status cleared", v & 32'h1_0030, 32'h0);

    // R7 data words
    rd32(DAT, w1);
    rd32(DAT, w2);
    check("R7 first word nonzero", {31'b0, w1 != 0}, 32'h1);
    check("R7 second word nonzero", {31'b0, w2 != 0}, 32'h1);
    check("R7 words differ", {31'b0, w1 != w2}, 32'h1);
    peek(ERR, v); check("R8 no underflow on valid reads", v, 32'h0);

    // R13 auto reseed
    for (int k = 0; k < 4; k++) rd32(DAT, w1);
    waitn(SEEDC + 3);
    peek(STA, v); check("R13 no reseed with auto off", v & 32'h20, 32'h0);
    wr32(CTL, 32'h70);
    waitn(SEEDC + 2);
    peek(STA, v); check("R13 reseed after enabling", v & 32'h20, 32'h20);
    wr32(CMD, 32'h10);
    for (int k = 0; k < RWORDS - 1; k++) rd32(DAT, w1);
    waitn(SEEDC + 3);
    peek(STA, v); check("R13 below threshold", v & 32'h20, 32'h0);
    rd32(DAT, w1);
    waitn(SEEDC + 3);
    peek(STA, v); check("R13 threshold reached", v & 32'h20, 32'h20);

    // reset mid-run
    do_reset();
    peek(CTL, v); check("R2 control after reset", v, 32'h60);
    peek(STA, v); check("R6 buffer empty after reset", v, 32'h0);
    check("R12 irq after second reset", {31'b0, irq}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nfails++;
      ntests++;
      $display("FAIL watchdog R1..all act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", ntests, nfails);
      $finish;
    end
  end
endmodule